// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer Unit

This block is a bus-mapped timer unit. A shared 16-bit prescaler counts down on every clock. It produces a single-cycle tick each time it reaches zero, and then restarts from its reload value. Each tick decrements every enabled 32-bit timer channel by one.

When a channel reaches zero and receives one more tick, it underflows. On underflow it either restarts from its own reload register or wraps to all ones. If its interrupt enable is set, it also pulses its own interrupt line for one cycle.

Software configures the unit through a 32-bit register port with a simple address and strobe protocol. Reads of the prescaler and of the counters return their live values. A fixed, read-only word reports the first interrupt number used by the unit and how many channels it has.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, the following values hold: the prescaler reload reads 0x0000FFFF, every channel counter and reload reads 0xFFFFFFFF, every channel control reads 0, and all interrupt lines are low.
- R2: Offset 0x308 always reads 0x100 | (interrupt base << 3) | channel count, which is 0x142 with the defaults (base 8, 2 channels). Writes to 0x308 have no effect. Any offset that is not mapped reads as 0.
- R3: A write to offset 0x304 does two things: it stores the low 16 bits of the data as the prescaler reload, and it restarts the live prescaler count at that value. A write to offset 0x300 (the live count) has no effect.
- R4: The live prescaler count (read at 0x300) falls by one per clock. In the cycle where it is 0, a tick occurs and the next value is the reload. Enabled channels therefore decrement once every (reload + 1) clocks.
- R5: The channel counter is at 0x310 + 0x10·i and the channel reload is at 0x314 + 0x10·i. A write to either stores the full 32-bit value, and both read back what was written while the channel is disabled.
- R6: The channel control register is at 0x318 + 0x10·i, with these bits: bit 0 enable, bit 1 restart, bit 2 load, bit 3 interrupt enable. Only bits 0, 1 and 3 are stored. A read returns the stored bits in those same positions and zeros everywhere else.
- R7: Writing control with bit 2 set copies the channel reload value into its counter on that write.
- R8: A tick that finds an enabled counter at 0 causes an underflow. On underflow the counter loads its reload value if restart is set, and 0xFFFFFFFF otherwise. The channel then keeps counting.
- R9: An underflow with interrupt enable set raises interrupt line i for exactly the cycle after the underflow edge. An underflow with interrupt enable clear raises no interrupt.
- R10: A disabled channel holds its counter value across ticks.
- R11: Channels count and interrupt independently. The underflow of one channel affects neither the other channel's interrupt line nor its counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a write takes effect on the edge where psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr (combinational) |
| tmr_irq | output | NUM_TMR | One interrupt pulse line per channel (line i is interrupt base + i) |

## Verification
The hardest situation to reach is an underflow on an exact, predictable edge. With the reset prescaler period of 65536 clocks, an underflow is far outside a short run. The bench first restarts the prescaler at 0xFFFF, which freezes the channels for the whole setup. It then loads the counters and controls. Finally it writes a small prescaler reload, and that write edge becomes cycle zero of a counted window. The bench watches the counter reads and the interrupt lines on every cycle of that window, at the exact cycles computed from the reload value. This is how it tests restart versus wrap, single-cycle interrupt pulses, and channel independence.

// File: rtl/tu_pkg.sv
// Package: shared register map, control bit positions and the stored
// control type of the prescaled timer unit.
// Assumes byte offsets on a 12-bit address and a 32-bit data path.
package tu_pkg;

    localparam int TU_DW = 32;

    localparam logic [11:0] OFS_SCL_CNT = 12'h300;
    localparam logic [11:0] OFS_SCL_RLD = 12'h304;
    localparam logic [11:0] OFS_CFG     = 12'h308;
    localparam int          OFS_TMR0    = 'h310;
    localparam int          TMR_STRIDE  = 'h10;

    localparam int SUB_CNT = 0;
    localparam int SUB_RLD = 4;
    localparam int SUB_CTL = 8;

    localparam int CB_EN = 0;
    localparam int CB_RS = 1;
    localparam int CB_LD = 2;
    localparam int CB_IE = 3;

    typedef struct packed {
        logic ie;
        logic rs;
        logic en;
    } ctl_t;

    // Byte offset of register 'sub' of channel 'idx'.
    function automatic logic [11:0] tmr_addr(input int idx, input int sub);
        return 12'(OFS_TMR0 + idx * TMR_STRIDE + sub);
    endfunction

    // Read-only configuration word.
    function automatic logic [31:0] cfg_word(input int n_tmr, input int irq_base);
        return 32'h100 | (32'(irq_base) << 3) | 32'(n_tmr);
    endfunction

endpackage

// File: rtl/tu_prescaler.sv
// Module: shared prescaler. Counts down every clock and flags a tick in the
// cycle its count is zero, then reloads. A reload write restarts the count.
// Assumes the write strobe is a single-cycle qualified bus write.
module tu_prescaler #(
    parameter int SCL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_rld,
    input  logic [SCL_W-1:0] wdata,
    output logic [SCL_W-1:0] cnt_o,
    output logic [SCL_W-1:0] rld_o,
    output logic             tick_o
);

    logic [SCL_W-1:0] cnt_q;
    logic [SCL_W-1:0] rld_q;

    // Reload register and down-counter with restart on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            rld_q <= '1;
        end else if (wr_rld) begin
            rld_q <= wdata;
            cnt_q <= wdata;
        end else if (cnt_q == '0) begin
            cnt_q <= rld_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Tick is asserted during the cycle the count sits at zero.
    assign tick_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;

endmodule

// File: rtl/tu_channel.sv
// Module: one down-counting timer channel with counter, reload and control
// storage. Decrements on prescaler ticks while enabled; on underflow it
// restarts or wraps to all ones and may pulse its registered interrupt.
// Assumes write strobes are mutually exclusive (distinct offsets).
module tu_channel
    import tu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [TU_DW-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output ctl_t             ctl_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    ctl_t             ctl_q;
    logic             irq_q;
    logic             load_req;
    logic             at_zero;
    logic             step;
    logic             uflow;

    // Decode of this cycle's events.
    always_comb begin
        load_req = wr_ctl && wdata[CB_LD];
        at_zero  = (cnt_q == '0);
        step     = tick && ctl_q.en && !wr_cnt && !load_req;
        uflow    = step && at_zero;
    end

    // Counter update: bus write, forced load, then tick-driven count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (wr_cnt) begin
            cnt_q <= wdata[CNT_W-1:0];
        end else if (load_req) begin
            cnt_q <= rld_q;
        end else if (step) begin
            if (at_zero) begin
                cnt_q <= ctl_q.rs ? rld_q : '1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Reload and control storage; the load bit is not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '1;
            ctl_q <= '0;
        end else begin
            if (wr_rld) begin
                rld_q <= wdata[CNT_W-1:0];
            end
            if (wr_ctl) begin
                ctl_q.en <= wdata[CB_EN];
                ctl_q.rs <= wdata[CB_RS];
                ctl_q.ie <= wdata[CB_IE];
            end
        end
    end

    // Registered one-cycle interrupt pulse per underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= uflow && ctl_q.ie;
        end
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = ctl_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/tu_rdmux.sv
// Module: read-data selection for the timer unit register map.
// Returns live counts, stored registers and the fixed configuration word;
// unmapped offsets read as zero. Purely combinational.
module tu_rdmux
    import tu_pkg::*;
#(
    parameter int NUM_TMR  = 2,
    parameter int SCL_W    = 16,
    parameter int CNT_W    = 32,
    parameter int IRQ_BASE = 8
) (
    input  logic [11:0]                    paddr,
    input  logic [SCL_W-1:0]               scl_cnt,
    input  logic [SCL_W-1:0]               scl_rld,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]  rld,
    input  ctl_t [NUM_TMR-1:0]             ctl,
    output logic [TU_DW-1:0]               rdata
);

    localparam logic [TU_DW-1:0] CFG = cfg_word(NUM_TMR, IRQ_BASE);

    // Address compare against every mapped register.
    always_comb begin
        rdata = '0;
        if (paddr == OFS_SCL_CNT) rdata = TU_DW'(scl_cnt);
        if (paddr == OFS_SCL_RLD) rdata = TU_DW'(scl_rld);
        if (paddr == OFS_CFG)     rdata = CFG;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (paddr == tmr_addr(i, SUB_CNT)) rdata = TU_DW'(cnt[i]);
            if (paddr == tmr_addr(i, SUB_RLD)) rdata = TU_DW'(rld[i]);
            if (paddr == tmr_addr(i, SUB_CTL)) begin
                rdata        = '0;
                rdata[CB_EN] = ctl[i].en;
                rdata[CB_RS] = ctl[i].rs;
                rdata[CB_IE] = ctl[i].ie;
            end
        end
    end

endmodule

// File: rtl/tick_timer_unit.sv
// Module: top of the prescaled timer unit. Decodes bus writes, instantiates
// the shared prescaler and NUM_TMR channels, and drives the read mux.
// Assumes NUM_TMR <= 7, IRQ_BASE < 32, CNT_W <= 32, SCL_W <= 16.
module tick_timer_unit
    import tu_pkg::*;
#(
    parameter int NUM_TMR  = 2,
    parameter int SCL_W    = 16,
    parameter int CNT_W    = 32,
    parameter int IRQ_BASE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [11:0]        paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic [NUM_TMR-1:0] tmr_irq
);

    logic                         bus_wr;
    logic                         wr_scl;
    logic                         tick;
    logic [SCL_W-1:0]             scl_cnt;
    logic [SCL_W-1:0]             scl_rld;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_TMR-1:0][CNT_W-1:0] rld_q;
    ctl_t [NUM_TMR-1:0]           ctl_q;

    // Qualified write strobe and prescaler reload select.
    always_comb begin
        bus_wr = psel && penable && pwrite;
        wr_scl = bus_wr && (paddr == OFS_SCL_RLD);
    end

    tu_prescaler #(
        .SCL_W (SCL_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_rld (wr_scl),
        .wdata  (pwdata[SCL_W-1:0]),
        .cnt_o  (scl_cnt),
        .rld_o  (scl_rld),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        logic wr_c;
        logic wr_r;
        logic wr_k;

        // Per-channel register select.
        always_comb begin
            wr_c = bus_wr && (paddr == tmr_addr(g, SUB_CNT));
            wr_r = bus_wr && (paddr == tmr_addr(g, SUB_RLD));
            wr_k = bus_wr && (paddr == tmr_addr(g, SUB_CTL));
        end

        tu_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .wr_cnt (wr_c),
            .wr_rld (wr_r),
            .wr_ctl (wr_k),
            .wdata  (pwdata),
            .cnt_o  (cnt_q[g]),
            .rld_o  (rld_q[g]),
            .ctl_o  (ctl_q[g]),
            .irq_o  (tmr_irq[g])
        );
    end

    tu_rdmux #(
        .NUM_TMR  (NUM_TMR),
        .SCL_W    (SCL_W),
        .CNT_W    (CNT_W),
        .IRQ_BASE (IRQ_BASE)
    ) u_rd (
        .paddr   (paddr),
        .scl_cnt (scl_cnt),
        .scl_rld (scl_rld),
        .cnt     (cnt_q),
        .rld     (rld_q),
        .ctl     (ctl_q),
        .rdata   (prdata)
    );

endmodule

// File: rtl/tick_timer_unit_chk.sv
// Module: property checker for the timer unit, attached by bind.
// Watches the bus, the prescaler state and each channel's registers.
module tick_timer_unit_chk
    import tu_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int SCL_W   = 16,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          psel,
    input logic                          penable,
    input logic                          pwrite,
    input logic [11:0]                   paddr,
    input logic [31:0]                   pwdata,
    input logic [NUM_TMR-1:0]            tmr_irq,
    input logic                          tick,
    input logic [SCL_W-1:0]              scl_cnt,
    input logic [SCL_W-1:0]              scl_rld,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_TMR-1:0][CNT_W-1:0] rld_q,
    input logic [NUM_TMR-1:0][2:0]       ctl_q
);

    logic wr_any;
    logic wr_pre;

    // Independent decode of bus writes.
    always_comb begin
        wr_any = psel && penable && pwrite;
        wr_pre = wr_any && (paddr == OFS_SCL_RLD);
    end

    AST_SCL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pre |=> (scl_rld == $past(pwdata[SCL_W-1:0])) && (scl_cnt == $past(pwdata[SCL_W-1:0]))); // R3

    AST_SCL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pre && scl_cnt != '0) |=> scl_cnt == $past(scl_cnt) - 1'b1); // R4

    AST_SCL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pre && scl_cnt == '0) |=> scl_cnt == $past(scl_rld)); // R4

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        logic wr_c;
        logic wr_ld;

        // Channel write events seen from the bus.
        always_comb begin
            wr_c  = wr_any && (paddr == tmr_addr(g, SUB_CNT));
            wr_ld = wr_any && (paddr == tmr_addr(g, SUB_CTL)) && pwdata[CB_LD];
        end

        AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ld |=> cnt_q[g] == $past(rld_q[g])); // R7

        AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_q[g][0] && !wr_c && !wr_ld) |=> $stable(cnt_q[g])); // R10

        AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_irq[g] |-> $past(tick && ctl_q[g][0] && ctl_q[g][2] && cnt_q[g] == '0)); // R9
    end

endmodule

bind tick_timer_unit tick_timer_unit_chk #(
    .NUM_TMR (NUM_TMR),
    .SCL_W   (SCL_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .tmr_irq (tmr_irq),
    .tick    (tick),
    .scl_cnt (scl_cnt),
    .scl_rld (scl_rld),
    .cnt_q   (cnt_q),
    .rld_q   (rld_q),
    .ctl_q   (ctl_q)
);

// File: tb/tick_timer_unit_tb.sv
// Bench: vector table of register accesses, then directed timing tests.
module tick_timer_unit_tb;

    localparam int CLK_P = 10;
    localparam int NV    = 20;

    // {read, offset, data-or-expected, requirement number}
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 12'h304, 32'h0000FFFF, 4'd1},  // R1 prescaler reload
        {1'b1, 12'h310, 32'hFFFFFFFF, 4'd1},  // R1 counter 0
        {1'b1, 12'h314, 32'hFFFFFFFF, 4'd1},  // R1 reload 0
        {1'b1, 12'h318, 32'h00000000, 4'd1},  // R1 control 0
        {1'b1, 12'h328, 32'h00000000, 4'd1},  // R1 control 1
        {1'b1, 12'h308, 32'h00000142, 4'd2},  // R2 config word
        {1'b0, 12'h308, 32'hFFFFFFFF, 4'd2},  // R2 write ignored
        {1'b1, 12'h308, 32'h00000142, 4'd2},  // R2
        {1'b0, 12'h314, 32'h12345678, 4'd5},  // R5
        {1'b1, 12'h314, 32'h12345678, 4'd5},  // R5
        {1'b0, 12'h310, 32'h000000AA, 4'd5},  // R5
        {1'b1, 12'h310, 32'h000000AA, 4'd5},  // R5
        {1'b0, 12'h324, 32'h00000055, 4'd7},  // R7 reload 1
        {1'b0, 12'h328, 32'hFFFFFFFE, 4'd6},  // R6 all bits but enable
        {1'b1, 12'h328, 32'h0000000A, 4'd6},  // R6 masked readback
        {1'b1, 12'h320, 32'h00000055, 4'd7},  // R7 load copied reload
        {1'b0, 12'h304, 32'hABCD1234, 4'd3},  // R3
        {1'b1, 12'h304, 32'h00001234, 4'd3},  // R3 low 16 bits
        {1'b1, 12'h3F0, 32'h00000000, 4'd2},  // R2 unmapped
        {1'b1, 12'h318, 32'h00000000, 4'd6}   // R6
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic [1:0]  tmr_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    tick_timer_unit u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .tmr_irq (tmr_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Two-edge write; called and returns on a falling edge.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Combinational read sampled before the next edge; one edge consumed.
    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int n0, n1;
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 irq low after reset", 32'(tmr_irq), 32'h0);
        @(negedge clk);

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][48]) begin
                bus_rd(VEC[k][47:36], rv);
                chk($sformatf("R%0d table[%0d]", VEC[k][3:0], k), rv, VEC[k][35:4]);
            end else begin
                bus_wr(VEC[k][47:36], VEC[k][35:4]);
            end
        end

        // R3/R4: live prescaler count after restart, step and wrap.
        bus_wr(12'h304, 32'd9);
        bus_rd(12'h300, rv); chk("R3 restart value", rv, 32'd9);
        repeat (3) @(negedge clk);
        bus_rd(12'h300, rv); chk("R4 count down", rv, 32'd5);
        bus_wr(12'h300, 32'd7);
        bus_rd(12'h300, rv); chk("R3 live count write ignored", rv, 32'd2);
        repeat (2) @(negedge clk);
        bus_rd(12'h300, rv); chk("R4 reload after zero", rv, 32'd9);

        // R8/R9: restart with interrupt, period 4, counter from 2.
        bus_wr(12'h304, 32'h0000FFFF);
        bus_wr(12'h314, 32'd2);
        bus_wr(12'h318, 32'hF);
        bus_wr(12'h304, 32'd3);
        psel = 1'b1; pwrite = 1'b0; paddr = 12'h310; n0 = 0;
        for (int j = 1; j <= 25; j++) begin
            @(negedge clk);
            #1;
            if (tmr_irq[0]) n0++;
            if (j == 6)  chk("R4 one tick per period", prdata, 32'd1);
            if (j == 11) chk("R4 reached zero", prdata, 32'd0);
            if (j == 12) begin
                chk("R8 restart from reload", prdata, 32'd2);
                chk("R9 irq after underflow", 32'(tmr_irq[0]), 32'd1);
            end
            if (j == 13) chk("R9 irq one cycle", 32'(tmr_irq[0]), 32'd0);
        end
        psel = 1'b0;
        chk("R9 pulse count", 32'(n0), 32'd2);
        @(negedge clk);

        // R8/R10/R11: wrap without restart on channel 1, channel 0 disabled.
        bus_wr(12'h304, 32'h0000FFFF);
        bus_wr(12'h318, 32'h0);
        bus_wr(12'h310, 32'd5);
        bus_wr(12'h320, 32'd1);
        bus_wr(12'h328, 32'h9);
        bus_wr(12'h304, 32'd1);
        psel = 1'b1; pwrite = 1'b0; paddr = 12'h320; n0 = 0;
        for (int j = 1; j <= 7; j++) begin
            @(negedge clk);
            #1;
            if (tmr_irq[0]) n0++;
            if (j == 3) chk("R4 channel 1 at zero", prdata, 32'd0);
            if (j == 4) begin
                chk("R8 wrap to all ones", prdata, 32'hFFFFFFFF);
                chk("R11 own line raised", 32'(tmr_irq[1]), 32'd1);
            end
            if (j == 7) chk("R8 keeps counting", prdata, 32'hFFFFFFFE);
        end
        psel = 1'b0;
        chk("R11 other line quiet", 32'(n0), 32'd0);
        @(negedge clk);
        bus_rd(12'h310, rv); chk("R10 disabled channel holds", rv, 32'd5);

        // R9: underflow with interrupt enable clear.
        bus_wr(12'h304, 32'h0000FFFF);
        bus_wr(12'h320, 32'd0);
        bus_wr(12'h328, 32'h1);
        bus_wr(12'h304, 32'd1);
        psel = 1'b1; pwrite = 1'b0; paddr = 12'h320; n1 = 0;
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            #1;
            if (tmr_irq[1]) n1++;
            if (j == 3) chk("R8 underflow without ie", prdata, 32'hFFFFFFFF);
        end
        psel = 1'b0;
        chk("R9 no irq when disabled", 32'(n1), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule